// File: doc/BRIEF.md
# USB Host Interrupt Status Controller

This block keeps the interrupt status and interrupt enable registers of a USB host controller and drives a single level interrupt request toward the host bus. Six hardware event inputs set status bits: a root hub change pulse, the level of frame-number bit 15, a system error pulse, the level of resume signaling seen on the bus, a start-of-frame pulse and a scheduling overrun pulse. A 2-bit wrapping counter records scheduling overruns.

Software reaches the registers through a command-code port. One cycle of `cmd_valid_i` carries an 8-bit code and, for writes, a 32-bit data word. Status bits are cleared by writing ones. Enable bits are set by writing ones. Read data is registered. While the system error bit is set, the `halt_o` output tells the surrounding controller to stop all processing and signaling. Only a reset of this block removes that bit.

Top module: `usbh_irq_ctrl`

## Requirements
- R1: Status layout is: bit 0 scheduling overrun, bit 2 start of frame, bit 3 resume detected, bit 4 unrecoverable error, bit 5 frame overflow, bit 6 root hub change. Bit 1 and bits 7..31 always read 0. Status is read with code 0x03.
- R2: The frame overflow bit is set on every change of `frame_msb_i`, from 0 to 1 and from 1 to 0. The previous value is taken as 0 after reset. A steady level sets nothing.
- R3: The resume bit is set only on a 0-to-1 change of `resume_sig_i`, and only while `sw_resume_i` is low. A high level that is held does not set the bit again after it has been cleared.
- R4: Pulses on `rh_change_i`, `sof_i` and `overrun_i` set their status bits at the clock edge that samples them.
- R5: Each `overrun_i` pulse increments a 2-bit counter that wraps from 3 to 0. The counter is read with code 0x05 in bits [1:0], and all other bits read 0.
- R6: A `sys_err_i` pulse sets bit 4, and `halt_o` is high while bit 4 is set. Writing 1 to bit 4 does not clear it. Only reset clears it.
- R7: Code 0x84 writes the enable register: a 1 sets the bit and a 0 leaves it unchanged. Bit 31 is the master enable. Only bits 31, 6..2 and 0 can be written, and all others read 0. Code 0x04 reads the register.
- R8: Code 0x83 clears each status bit written with 1. A 0 has no effect. When an event and a clear of the same bit fall in one cycle, the bit stays set.
- R9: `irq_o` is a registered level. It is high exactly when the master enable is set and some status bit and its enable are both set. It follows the register contents at the same edge that updates them.
- R10: `rdata_o` loads at the edge that samples a read code and holds until the next read. It shows the register contents as they were before updates made in that same cycle. After reset, all registers, `irq_o` and `halt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rh_change_i | input | 1 | Root hub change event pulse |
| frame_msb_i | input | 1 | Frame number bit 15 level |
| sys_err_i | input | 1 | System error event pulse |
| resume_sig_i | input | 1 | Resume signaling seen on the bus (level) |
| sw_resume_i | input | 1 | Software has put the controller into resume state |
| sof_i | input | 1 | Start-of-frame event pulse |
| overrun_i | input | 1 | Scheduling overrun event pulse |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_code_i | input | 8 | Command code |
| cmd_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request |
| halt_o | output | 1 | Stop processing while the error bit is set |

## Verification
Two pairs of functions can land on the same cycle. A hardware event can meet a software clear of the same status bit, and a read can meet an event that changes the bit being read. The bench drives the root hub pulse together with a 0x83 write that clears bit 6 and expects the bit to survive. It also issues a status read in the same cycle as a start-of-frame pulse, and expects that read to return the old value while the next read returns the new one.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
    localparam int REG_W  = 32;
    localparam int CODE_W = 8;
    localparam int CNT_W  = 2;

    localparam int B_SO   = 0;
    localparam int B_SOF  = 2;
    localparam int B_RD   = 3;
    localparam int B_UE   = 4;
    localparam int B_FNO  = 5;
    localparam int B_RHSC = 6;
    localparam int B_MIE  = 31;

    localparam logic [REG_W-1:0] STS_MASK    = (REG_W'(1) << B_SO)  | (REG_W'(1) << B_SOF) |
                                               (REG_W'(1) << B_RD)  | (REG_W'(1) << B_UE)  |
                                               (REG_W'(1) << B_FNO) | (REG_W'(1) << B_RHSC);
    localparam logic [REG_W-1:0] EN_MASK     = STS_MASK | (REG_W'(1) << B_MIE);
    localparam logic [REG_W-1:0] STICKY_MASK = REG_W'(1) << B_UE;

    localparam logic [CODE_W-1:0] CMD_STS_RD = 8'h03;
    localparam logic [CODE_W-1:0] CMD_STS_WR = 8'h83;
    localparam logic [CODE_W-1:0] CMD_EN_RD  = 8'h04;
    localparam logic [CODE_W-1:0] CMD_EN_WR  = 8'h84;
    localparam logic [CODE_W-1:0] CMD_CNT_RD = 8'h05;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } top_state_t;
endpackage

// File: rtl/usbh_irq_edge.sv
module usbh_irq_edge #(
    parameter bit TOGGLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic hit_o
);
    logic prev_d, prev_q;

    always_comb prev_d = sig_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    generate
        if (TOGGLE) begin : g_toggle
            assign hit_o = sig_i ^ prev_q;
        end else begin : g_rise
            assign hit_o = sig_i & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status #(
    parameter int              W      = 32,
    parameter logic [W-1:0]    MASK   = '1,
    parameter logic [W-1:0]    STICKY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] sts_nxt_o,
    output logic [W-1:0] sts_o
);
    logic [W-1:0] sts_d, sts_q;

    always_comb begin
        sts_d = ((sts_q & ~(clr_i & ~STICKY)) | set_i) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts_nxt_o = sts_d;
    assign sts_o     = sts_q;

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(sts_q) & ~sts_q) & STICKY) == '0));

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & MASK) != '0) |=> ((sts_q & $past(set_i & MASK)) == $past(set_i & MASK)));
endmodule

// File: rtl/usbh_irq_enable.sv
module usbh_irq_enable #(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_nxt_o,
    output logic [W-1:0] en_o
);
    logic [W-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_i) en_d = en_q | (wdata_i & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_nxt_o = en_d;
    assign en_o     = en_q;

    // R7
    no_enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(en_q) & ~en_q) == '0));
endmodule

// File: rtl/usbh_irq_ctrl.sv
module usbh_irq_ctrl
    import usbh_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rh_change_i,
    input  logic              frame_msb_i,
    input  logic              sys_err_i,
    input  logic              resume_sig_i,
    input  logic              sw_resume_i,
    input  logic              sof_i,
    input  logic              overrun_i,
    input  logic              cmd_valid_i,
    input  logic [CODE_W-1:0] cmd_code_i,
    input  logic [REG_W-1:0]  cmd_wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o,
    output logic              halt_o
);
    logic             fno_hit, rd_rise;
    logic [REG_W-1:0] set_vec, clr_vec;
    logic [REG_W-1:0] sts_q, sts_nxt, en_q, en_nxt;
    logic             sts_wr, en_wr;
    top_state_t       st_d, st_q;

    usbh_irq_edge #(.TOGGLE(1'b1)) u_frame_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(frame_msb_i), .hit_o(fno_hit));

    usbh_irq_edge #(.TOGGLE(1'b0)) u_resume_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(resume_sig_i), .hit_o(rd_rise));

    always_comb begin
        set_vec         = '0;
        set_vec[B_SO]   = overrun_i;
        set_vec[B_SOF]  = sof_i;
        set_vec[B_RD]   = rd_rise & ~sw_resume_i;
        set_vec[B_UE]   = sys_err_i;
        set_vec[B_FNO]  = fno_hit;
        set_vec[B_RHSC] = rh_change_i;
        sts_wr          = cmd_valid_i && (cmd_code_i == CMD_STS_WR);
        en_wr           = cmd_valid_i && (cmd_code_i == CMD_EN_WR);
        clr_vec         = sts_wr ? cmd_wdata_i : '0;
    end

    usbh_irq_status #(.W(REG_W), .MASK(STS_MASK), .STICKY(STICKY_MASK)) u_status (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
        .sts_nxt_o(sts_nxt), .sts_o(sts_q));

    usbh_irq_enable #(.W(REG_W), .MASK(EN_MASK)) u_enable (
        .clk(clk), .rst_n(rst_n), .wr_i(en_wr), .wdata_i(cmd_wdata_i),
        .en_nxt_o(en_nxt), .en_o(en_q));

    always_comb begin
        st_d = st_q;
        if (overrun_i) st_d.cnt = st_q.cnt + 1'b1;
        if (cmd_valid_i) begin
            case (cmd_code_i)
                CMD_STS_RD: st_d.rdata = sts_q;
                CMD_EN_RD:  st_d.rdata = en_q;
                CMD_CNT_RD: st_d.rdata = {{(REG_W-CNT_W){1'b0}}, st_q.cnt};
                default:    st_d.rdata = st_q.rdata;
            endcase
        end
        st_d.irq = en_nxt[B_MIE] & (|(sts_nxt & en_nxt & STS_MASK));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = st_q.irq;
    assign halt_o  = sts_q[B_UE];

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (en_q[B_MIE] & (|(sts_q & en_q))));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_i |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    // R3
    no_sw_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_resume_i && !sts_q[B_RD]) |=> !sts_q[B_RD]);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q & ~STS_MASK) == '0);
endmodule

// File: tb/usbh_irq_ctrl_bench.sv
module usbh_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rh_change_i = 0, frame_msb_i = 0, sys_err_i = 0;
    logic        resume_sig_i = 0, sw_resume_i = 0, sof_i = 0, overrun_i = 0;
    logic        cmd_valid_i = 0;
    logic [7:0]  cmd_code_i = 0;
    logic [31:0] cmd_wdata_i = 0;
    logic [31:0] rdata_o;
    logic        irq_o, halt_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usbh_irq_ctrl u_usbh_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rh_change_i(rh_change_i), .frame_msb_i(frame_msb_i),
        .sys_err_i(sys_err_i), .resume_sig_i(resume_sig_i), .sw_resume_i(sw_resume_i),
        .sof_i(sof_i), .overrun_i(overrun_i), .cmd_valid_i(cmd_valid_i),
        .cmd_code_i(cmd_code_i), .cmd_wdata_i(cmd_wdata_i), .rdata_o(rdata_o),
        .irq_o(irq_o), .halt_o(halt_o));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] c, input logic [31:0] d);
        @(negedge clk);
        cmd_valid_i = 1; cmd_code_i = c; cmd_wdata_i = d;
        @(negedge clk);
        cmd_valid_i = 0; cmd_code_i = 0; cmd_wdata_i = 0;
    endtask

    task automatic rd(input logic [7:0] c, output logic [31:0] v);
        cmd(c, 32'h0);
        v = rdata_o;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: overrun_i = 1;
            2: sof_i = 1;
            4: sys_err_i = 1;
            default: rh_change_i = 1;
        endcase
        @(negedge clk);
        overrun_i = 0; sof_i = 0; sys_err_i = 0; rh_change_i = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h03, v); check("R10 status after reset", v, 0);
        rd(8'h04, v); check("R10 enable after reset", v, 0);
        rd(8'h05, v); check("R10 count after reset", v, 0);
        check("R10 irq after reset", {31'b0, irq_o}, 0);
        check("R10 halt after reset", {31'b0, halt_o}, 0);
    endtask

    task automatic t_mie_gate();
        cmd(8'h84, 32'h0000_0004);
        pulse(2);
        check("R9 no irq without master enable", {31'b0, irq_o}, 0);
        cmd(8'h84, 32'h8000_0000);
        check("R9 irq once master enable set", {31'b0, irq_o}, 1);
        cmd(8'h83, 32'h0000_0004);
        check("R9 irq drops after clear", {31'b0, irq_o}, 0);
    endtask

    task automatic t_sof_read_race();
        logic [31:0] v;
        @(negedge clk);
        sof_i = 1; cmd_valid_i = 1; cmd_code_i = 8'h03;
        @(negedge clk);
        sof_i = 0; cmd_valid_i = 0; cmd_code_i = 0;
        check("R10 read shows old status", rdata_o, 0);
        check("R4 irq with sof", {31'b0, irq_o}, 1);
        rd(8'h03, v); check("R4 sof bit set", v, 32'h4);
        cmd(8'h83, 32'h4);
        check("R8 irq low after w1c", {31'b0, irq_o}, 0);
    endtask

    task automatic t_enable_w1s();
        logic [31:0] v;
        cmd(8'h84, 32'h0000_0041);
        cmd(8'h84, 32'h0000_0000);
        rd(8'h04, v); check("R7 zeros leave enables", v, 32'h8000_0045);
        cmd(8'h84, 32'h7FFF_FF82);
        rd(8'h04, v); check("R7 reserved enable bits read 0", v, 32'h8000_0045);
    endtask

    task automatic t_w1c_race();
        logic [31:0] v;
        pulse(6);
        check("R9 irq on enabled rhsc", {31'b0, irq_o}, 1);
        cmd(8'h83, 32'h0);
        rd(8'h03, v); check("R8 zero write keeps bit", v, 32'h40);
        @(negedge clk);
        rh_change_i = 1; cmd_valid_i = 1; cmd_code_i = 8'h83; cmd_wdata_i = 32'h40;
        @(negedge clk);
        rh_change_i = 0; cmd_valid_i = 0; cmd_code_i = 0; cmd_wdata_i = 0;
        rd(8'h03, v); check("R8 event wins over clear", v, 32'h40);
        cmd(8'h83, 32'h40);
        rd(8'h03, v); check("R8 bit cleared", v, 32'h0);
    endtask

    task automatic t_frame();
        logic [31:0] v;
        @(negedge clk); frame_msb_i = 1;
        @(negedge clk);
        rd(8'h03, v); check("R2 rise sets fno", v, 32'h20);
        cmd(8'h83, 32'h20);
        repeat (3) @(negedge clk);
        rd(8'h03, v); check("R2 steady level no set", v, 32'h0);
        frame_msb_i = 0;
        @(negedge clk);
        rd(8'h03, v); check("R2 fall sets fno", v, 32'h20);
        cmd(8'h83, 32'h20);
    endtask

    task automatic t_resume();
        logic [31:0] v;
        @(negedge clk); sw_resume_i = 1; resume_sig_i = 1;
        @(negedge clk);
        rd(8'h03, v); check("R3 software resume suppresses", v, 32'h0);
        sw_resume_i = 0;
        repeat (2) @(negedge clk);
        rd(8'h03, v); check("R3 held level no set", v, 32'h0);
        resume_sig_i = 0;
        @(negedge clk); resume_sig_i = 1;
        @(negedge clk);
        rd(8'h03, v); check("R3 bus resume rise sets", v, 32'h8);
        cmd(8'h83, 32'h8);
        repeat (2) @(negedge clk);
        rd(8'h03, v); check("R3 no reset while held", v, 32'h0);
        resume_sig_i = 0;
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) pulse(0);
        rd(8'h05, v); check("R5 count three", v, 32'h3);
        pulse(0);
        rd(8'h05, v); check("R5 count wraps", v, 32'h0);
        pulse(0);
        rd(8'h05, v); check("R5 count after wrap", v, 32'h1);
        rd(8'h03, v); check("R4 overrun bit", v, 32'h1);
        cmd(8'h83, 32'h1);
    endtask

    task automatic t_error();
        logic [31:0] v;
        @(negedge clk);
        sys_err_i = 1; sof_i = 1; overrun_i = 1; rh_change_i = 1; frame_msb_i = 1;
        @(negedge clk);
        sys_err_i = 0; sof_i = 0; overrun_i = 0; rh_change_i = 0;
        resume_sig_i = 1;
        @(negedge clk);
        resume_sig_i = 0;
        rd(8'h03, v); check("R1 full status layout", v, 32'h7D);
        check("R6 halt high", {31'b0, halt_o}, 1);
        cmd(8'h83, 32'hFFFF_FFFF);
        rd(8'h03, v); check("R6 error bit survives w1c", v, 32'h10);
        check("R6 halt stays", {31'b0, halt_o}, 1);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; frame_msb_i = 0;
        @(negedge clk);
        check("R6 halt cleared by reset", {31'b0, halt_o}, 0);
        rd(8'h03, v); check("R6 status cleared by reset", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mie_gate();
        t_sof_read_race();
        t_enable_w1s();
        t_w1c_race();
        t_frame();
        t_resume();
        t_overrun();
        t_error();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule